// File: doc/BRIEF.md
# Serial Register-Packet Command Master

This block lets on-chip logic program or query the parameter registers of an external video processor over a three-wire synchronous link. The link has an active-low select, a serial clock, a data output to the processor and a data input from it. Before a transfer, the user loads a packet into a small local byte buffer. A packet is a start word, a command word, an address word and at least one data word. The user then raises a request together with the packet length.

The master shifts the bytes out least significant bit first. Data changes on the falling clock edge, because the processor samples on the rising edge, and one idle clock period separates consecutive bytes. When the packet ends, select goes high for a fixed busy interval. The master then lowers select again and clocks in the single confirmation byte, which is a write acknowledge, read data or an error code. A one-cycle done pulse presents that byte together with a status code.

The serial clock half-period is a whole number of system clocks. With the default divider and a 200 MHz system clock the link runs at 400 kbit/s.

Top module: `sreg_cmd_master`

## Requirements
- R1: After reset: cs_n=1, sck=1, mosi=0, busy=0, done=0.
- R2: Buffer bytes 0 to len-1 go out in index order, each least significant bit first. mosi changes only on the cycle sck falls and is stable while sck is high with select low.
- R3: cs_n stays low from acceptance until the last rising sck edge of the packet. Between two bytes, sck stays high for one extra full serial period (three half-periods in all from the last rise to the next fall).
- R4: Every sck level, and every idle step, lasts exactly CLK_DIV system clocks. sck is high whenever cs_n is high.
- R5: A request whose length is below 4 or above MAX_BYTES (32) sends nothing: cs_n and sck stay high. In the following cycle done pulses with status=2'b10, and rsp_data is left unchanged.
- R6: After the packet, cs_n is high for exactly BUSY_SCK serial periods (2*BUSY_SCK half-periods), with sck high and mosi=0.
- R7: After the busy interval, cs_n goes low and eight sck pulses follow. miso is sampled on each rising edge, least significant bit first. cs_n then returns high with a one-cycle done pulse, and rsp_data holds the byte.
- R8: At done, status=2'b01 when the received byte equals err_code, otherwise 2'b00.
- R9: busy is high from the cycle after an accepted request until the done cycle. A request arriving while busy is ignored.
- R10: Buffer writes while busy have no effect. Writes while idle store wr_data at wr_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_addr | input | 5 | Buffer byte index |
| wr_data | input | 8 | Buffer byte value |
| req | input | 1 | Start a packet transfer |
| req_len | input | 6 | Packet length in bytes |
| err_code | input | 8 | Response value treated as device error |
| miso | input | 1 | Serial data from the processor |
| cs_n | output | 1 | Active-low select |
| sck | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data to the processor |
| busy | output | 1 | Transfer or busy interval in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 ok, 01 device error, 10 length error |
| rsp_data | output | 8 | Captured response byte |

## Verification
The hardest conditions to reach from the ports are a second request and a buffer write that arrive in the middle of a transfer. The first must be dropped. The second must change neither the bytes still to be shifted nor any later packet. The stimulus injects both while a five-byte packet is on the wire, aiming at a byte that has not gone out yet, and then repeats the same packet. The response path is driven by a bench model that places each miso bit during the low phase of sck. One response is chosen to equal err_code so that the device-error status appears.

// File: rtl/sreg_cmd_master.sv
`timescale 1ns/1ps
module sreg_cmd_master #(
  parameter int CLK_DIV   = 250,
  parameter int BUSY_SCK  = 16,
  parameter int MAX_BYTES = 32,
  parameter int MIN_BYTES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [$clog2(MAX_BYTES)-1:0]   wr_addr,
  input  logic [7:0]                     wr_data,
  input  logic                           req,
  input  logic [$clog2(MAX_BYTES):0]     req_len,
  input  logic [7:0]                     err_code,
  input  logic                           miso,
  output logic                           cs_n,
  output logic                           sck,
  output logic                           mosi,
  output logic                           busy,
  output logic                           done,
  output logic [1:0]                     status,
  output logic [7:0]                     rsp_data
);
  localparam int AW = $clog2(MAX_BYTES);
  localparam int LW = AW + 1;
  localparam int DW = $clog2(CLK_DIV);
  localparam int HW = $clog2(2*BUSY_SCK + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_GAP, S_HOLD, S_READ, S_FIN} state_t;

  state_t          st;
  logic [DW-1:0]   div;
  logic [HW-1:0]   hcnt;
  logic [AW-1:0]   idx, last;
  logic [2:0]      bi;
  logic            ph;
  logic [7:0]      rx;
  logic [7:0]      mem [MAX_BYTES];

  wire tick   = (st != S_IDLE) && (div == DW'(CLK_DIV-1));
  wire len_ok = (req_len >= LW'(MIN_BYTES)) && (req_len <= LW'(MAX_BYTES));
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk)
    if (wr_en && st == S_IDLE) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div      <= '0;
      hcnt     <= '0;
      idx      <= '0;
      last     <= '0;
      bi       <= '0;
      ph       <= 1'b0;
      rx       <= '0;
      cs_n     <= 1'b1;
      sck      <= 1'b1;
      mosi     <= 1'b0;
      done     <= 1'b0;
      status   <= 2'b00;
      rsp_data <= '0;
    end else begin
      done <= 1'b0;
      div  <= (st == S_IDLE || tick) ? '0 : div + 1'b1;
      case (st)
        S_IDLE:
          if (req) begin
            if (len_ok) begin
              st   <= S_SHIFT;
              cs_n <= 1'b0;
              idx  <= '0;
              bi   <= '0;
              ph   <= 1'b0;
              last <= AW'(req_len - 1'b1);
            end else begin
              done   <= 1'b1;
              status <= 2'b10;
            end
          end
        S_SHIFT:
          if (tick) begin
            if (!ph) begin
              sck  <= 1'b0;
              mosi <= mem[idx][bi];
              ph   <= 1'b1;
            end else begin
              sck <= 1'b1;
              ph  <= 1'b0;
              if (bi == 3'd7) begin
                bi   <= '0;
                hcnt <= '0;
                if (idx == last) st <= S_HOLD;
                else begin
                  idx <= idx + 1'b1;
                  st  <= S_GAP;
                end
              end else bi <= bi + 1'b1;
            end
          end
        S_GAP:
          if (tick) begin
            if (hcnt == HW'(1)) st <= S_SHIFT;
            else hcnt <= hcnt + 1'b1;
          end
        S_HOLD:
          if (tick) begin
            if (hcnt == '0) begin
              cs_n <= 1'b1;
              mosi <= 1'b0;
            end
            if (hcnt == HW'(2*BUSY_SCK)) begin
              cs_n <= 1'b0;
              st   <= S_READ;
              hcnt <= '0;
              bi   <= '0;
              ph   <= 1'b0;
            end else hcnt <= hcnt + 1'b1;
          end
        S_READ:
          if (tick) begin
            if (!ph) begin
              sck <= 1'b0;
              ph  <= 1'b1;
            end else begin
              sck    <= 1'b1;
              ph     <= 1'b0;
              rx[bi] <= miso;
              if (bi == 3'd7) st <= S_FIN;
              else bi <= bi + 1'b1;
            end
          end
        S_FIN:
          if (tick) begin
            cs_n     <= 1'b1;
            done     <= 1'b1;
            rsp_data <= rx;
            status   <= (rx == err_code) ? 2'b01 : 2'b00;
            st       <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sreg_cmd_master_chk.sv
`timescale 1ns/1ps
module sreg_cmd_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       mosi,
  input logic       busy,
  input logic       done,
  input logic [1:0] status
);
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sck); // R4
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && sck) |-> $stable(mosi)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n); // R9
  AST_LEN_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (done && status == 2'b10) |-> (cs_n && $past(cs_n))); // R5
endmodule

bind sreg_cmd_master sreg_cmd_master_chk u_chk (.*);

// File: tb/sreg_cmd_master_test.sv
`timescale 1ns/1ps
module sreg_cmd_master_test;
  localparam int D = 3;
  localparam int B = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, req = 1'b0, miso = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0, err_code = 8'hE5;
  logic [5:0] req_len = '0;
  logic cs_n, sck, mosi, busy, done;
  logic [1:0] status;
  logic [7:0] rsp_data;

  sreg_cmd_master #(.CLK_DIV(D), .BUSY_SCK(B)) uut (.*);

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic cs, sck, mosi, miso, busy, done;
    logic [1:0] st;
    logic [7:0] rsp;
  } ent_t;

  ent_t q[$];
  logic [7:0] bufm [32];
  logic [7:0] last_rsp = '0;
  int checks = 0, errors = 0, cyc = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic push(logic c, logic s, logic m, logic mi, int n);
    for (int k = 0; k < n; k++) q.push_back('{c, s, m, mi, 1'b1, 1'b0, 2'b00, 8'h00});
  endtask

  task automatic build(int len, logic [7:0] resp);
    push(0, 1, 0, 0, D);
    for (int b = 0; b < len; b++) begin
      for (int i = 0; i < 8; i++) begin
        push(0, 0, bufm[b][i], 0, D);
        push(0, 1, bufm[b][i], 0, D);
      end
      if (b < len - 1) push(0, 1, bufm[b][7], 0, 2*D);
    end
    push(1, 1, 0, 0, 2*B*D);
    push(0, 1, 0, 0, D);
    for (int i = 0; i < 8; i++) begin
      push(0, 0, 0, resp[i], D);
      push(0, 1, 0, resp[i], D);
    end
    last_rsp = resp;
    q.push_back('{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, (resp == err_code) ? 2'b01 : 2'b00, resp});
  endtask

  always @(negedge clk) if (rst_n) begin
    ent_t e;
    cyc++;
    e = (q.size() != 0) ? q.pop_front() : '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'h00};
    check("R3/R6 cs_n", cs_n, e.cs);
    check("R4 sck", sck, e.sck);
    check("R2 mosi", mosi, e.mosi);
    check("R9 busy", busy, e.busy);
    check("R7 done", done, e.done);
    if (e.done) begin
      check("R8/R5 status", status, e.st);
      check("R7 rsp_data", rsp_data, e.rsp);
    end
    miso = e.miso;
  end

  task automatic wr(int a, logic [7:0] d, logic model);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    if (model) bufm[a] = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic send(int len, logic [7:0] resp);
    @(negedge clk); #1;
    req = 1'b1; req_len = 6'(len);
    if (len >= 4 && len <= 32) build(len, resp);
    else q.push_back('{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, last_rsp});
    @(negedge clk); #1;
    req = 1'b0;
  endtask

  task automatic quiet();
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state before release
    check("R1 cs_n", cs_n, 1); check("R1 sck", sck, 1); check("R1 mosi", mosi, 0);
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 32; a++) wr(a, 8'((a * 37 + 5) & 8'hFF), 1'b1);   // R10 idle writes
    send(4, 8'h3C);   quiet();   // R2 R3 R6 R7 minimum packet
    send(7, 8'hE5);   quiet();   // R8 device error code
    send(32, 8'hA1);  quiet();   // R2 maximum length
    send(33, 8'h00);  quiet();   // R5 too long
    send(3, 8'h00);   quiet();   // R5 too short
    send(0, 8'h00);   quiet();   // R5 empty
    send(5, 8'h96);
    repeat (20) @(negedge clk);
    #1 req = 1'b1; req_len = 6'd6;   // R9 ignored while busy
    @(negedge clk); #1 req = 1'b0;
    wr(4, 8'h5A, 1'b0);              // R10 ignored while busy
    quiet();
    send(5, 8'h01);   quiet();   // R10 old byte still sent
    wr(0, 8'hFF, 1'b1); wr(1, 8'h00, 1'b1); wr(2, 8'h81, 1'b1); wr(3, 8'h7E, 1'b1);
    send(4, 8'h00);   quiet();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule